// File: doc/BRIEF.md
# Event Vector Wake Controller

This block sits beside the instruction decoder of a small mesh-array processor core. It watches six register-write strobes: the externally written sensor input register, the four neighbour communication registers that this core reads from its mesh neighbours, and the core's own actuator output register. Each write is latched into a sticky bit of an 8-bit event vector. The two top bits of that vector are always zero. The vector is offered as an 8-bit operand so that a program can test which events are waiting. A clear strobe with a 3-bit index drops one bit.

The block also decides whether the program counter may advance. A halt strobe puts the core into idle only when no event is pending and none is being written in that cycle. While the core is idle, the first write event restarts it. Execution then resumes at the instruction after the halt, in the manner of an interrupt service routine, and that instruction usually clears the event that caused the wake. A one-cycle wake pulse marks the restart.

Top module: `event_wake_unit`

## Requirements
- R1: After reset the event vector is 0x00, idle is 0, wake is 0 and pcEnable is 1.
- R2: A write strobe sets its bit of the vector at the next clock edge. The bit map is: bit 0 for the sensor write, bits 1 to 4 for neighbour writes 0 to 3, and bit 5 for the actuator write.
- R3: A set bit stays set until a clear strobe names its index.
- R4: A clear strobe with index k (k from 0 to 5) zeroes only bit k at the next edge. Indices 6 and 7 change nothing.
- R5: When a clear and a write to the same bit land in the same cycle, the bit ends up set.
- R6: Bits 7 and 6 of the event vector are always 0.
- R7: A halt strobe while running enters idle at the next edge if the vector is zero and no write strobe is active in that cycle. While idle, pcEnable is 0.
- R8: A halt strobe while any bit is pending, or while a write strobe is active, leaves the core running.
- R9: While idle, a write in cycle t sets the vector at edge t+1. Idle drops and wake rises at edge t+2, and wake lasts exactly one cycle.
- R10: A halt strobe while idle has no effect. Wake is asserted only on the transition from idle to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| sensorWr | input | 1 | Write strobe of the sensor input register |
| nbrWr | input | NUM_NBR | Write strobes of the neighbour communication registers |
| actWr | input | 1 | Write strobe of the actuator output register |
| haltExec | input | 1 | Halt instruction is executing |
| clrEvent | input | 1 | Event-clear instruction is executing |
| clrIdx | input | 3 | Index of the event bit to clear |
| eventVec | output | 8 | Sticky event vector, readable as an operand |
| pcEnable | output | 1 | Program counter may advance |
| idle | output | 1 | Core is idle |
| wake | output | 1 | One-cycle pulse when the core leaves idle |

## Verification
The hardest situation to reach is the exact cycle in which the core leaves idle. The bench first has to arrive at an empty vector with a halt accepted, then inject a single write. It must then confirm that the vector bit appears one edge before the idle-to-run transition and the wake pulse. The bench reaches this state once for every event source. Each time, it clears the bit and halts again, so the core is back in idle for the next source. It also drives a halt in the same cycle as a write, and a clear in the same cycle as a write to the same bit. Those two collisions exercise the rule that an incoming event takes priority.

// File: rtl/evw_pkg.sv
package evw_pkg;
  localparam int VEC_W = 8;
  localparam int IDX_W = $clog2(VEC_W);

  typedef struct packed {
    logic             clrEn;
    logic [IDX_W-1:0] clrIdx;
  } evwStrobe_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_IDLE = 1'b1
  } evwState_t;
endpackage

// File: rtl/evw_vector.sv
module evw_vector
  import evw_pkg::*;
#(
  parameter int NUM_NBR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sensorWr,
  input  logic [NUM_NBR-1:0] nbrWr,
  input  logic               actWr,
  input  evwStrobe_t         strobe,
  output logic [VEC_W-1:0]   eventVec,
  output logic               anyPending,
  output logic               anySet
);
  localparam int LIVE = NUM_NBR + 2;

  logic [VEC_W-1:0] setMask;
  logic [VEC_W-1:0] clrMask;
  logic [VEC_W-1:0] vecQ;

  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    if (i == 0) begin : g_sensor
      assign setMask[i] = sensorWr;
    end else if (i <= NUM_NBR) begin : g_nbr
      assign setMask[i] = nbrWr[i-1];
    end else if (i == LIVE - 1) begin : g_act
      assign setMask[i] = actWr;
    end else begin : g_tied
      assign setMask[i] = 1'b0;
    end
    assign clrMask[i] = strobe.clrEn && (strobe.clrIdx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) vecQ <= '0;
    else       vecQ <= (vecQ & ~clrMask) | setMask;
  end

  assign eventVec   = vecQ;
  assign anyPending = |vecQ;
  assign anySet     = |setMask;
endmodule

// File: rtl/evw_ctrl.sv
module evw_ctrl
  import evw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltExec,
  input  logic             clrEvent,
  input  logic [IDX_W-1:0] clrIdx,
  input  logic             anyPending,
  input  logic             anySet,
  output evwStrobe_t       strobe,
  output logic             idle,
  output logic             wake
);
  evwState_t stateQ, stateD;
  logic      wakeQ, wakeD;

  always_comb begin
    stateD = stateQ;
    wakeD  = 1'b0;
    unique case (stateQ)
      ST_RUN: begin
        if (haltExec && !anyPending && !anySet) stateD = ST_IDLE;
      end
      ST_IDLE: begin
        if (anyPending) begin
          stateD = ST_RUN;
          wakeD  = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_RUN;
      wakeQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      wakeQ  <= wakeD;
    end
  end

  assign strobe.clrEn  = clrEvent;
  assign strobe.clrIdx = clrIdx;
  assign idle = (stateQ == ST_IDLE);
  assign wake = wakeQ;
endmodule

// File: rtl/event_wake_unit.sv
module event_wake_unit
  import evw_pkg::*;
#(
  parameter int NUM_NBR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sensorWr,
  input  logic [NUM_NBR-1:0] nbrWr,
  input  logic               actWr,
  input  logic               haltExec,
  input  logic               clrEvent,
  input  logic [2:0]         clrIdx,
  output logic [7:0]         eventVec,
  output logic               pcEnable,
  output logic               idle,
  output logic               wake
);
  evwStrobe_t strobe;
  logic       anyPending;
  logic       anySet;

  evw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .haltExec(haltExec), .clrEvent(clrEvent),
    .clrIdx(clrIdx), .anyPending(anyPending), .anySet(anySet),
    .strobe(strobe), .idle(idle), .wake(wake)
  );

  evw_vector #(.NUM_NBR(NUM_NBR)) u_vec (
    .clk(clk), .rstN(rstN), .sensorWr(sensorWr), .nbrWr(nbrWr),
    .actWr(actWr), .strobe(strobe), .eventVec(eventVec),
    .anyPending(anyPending), .anySet(anySet)
  );

  assign pcEnable = !idle;
endmodule

// File: rtl/evw_checker.sv
module evw_checker #(
  parameter int NUM_NBR = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               sensorWr,
  input logic [NUM_NBR-1:0] nbrWr,
  input logic               actWr,
  input logic               haltExec,
  input logic               clrEvent,
  input logic [2:0]         clrIdx,
  input logic [7:0]         eventVec,
  input logic               pcEnable,
  input logic               idle,
  input logic               wake
);
  logic anyWr;
  assign anyWr = sensorWr || (|nbrWr) || actWr;

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    eventVec[7:6] == 2'b00);

  p_sensor_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    sensorWr |=> eventVec[0]);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (eventVec[0] && !(clrEvent && clrIdx == 3'd0)) |=> eventVec[0]);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (nbrWr[0] && clrEvent && clrIdx == 3'd1) |=> eventVec[1]);

  p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (haltExec && !idle && eventVec == 8'd0 && !anyWr) |=> (idle && !pcEnable));

  p_halt_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (haltExec && !idle && (eventVec != 8'd0 || anyWr)) |=> !idle);

  p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    wake |=> !wake);

  p_wake_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wake) |-> ($fell(idle) && pcEnable));
endmodule

bind event_wake_unit evw_checker #(.NUM_NBR(NUM_NBR)) u_chk (.*);

// File: tb/sim_event_wake_unit.sv
`timescale 1ns/1ps
module sim_event_wake_unit;
  logic       clk = 1'b0;
  logic       rstN;
  logic       sensorWr, actWr, haltExec, clrEvent;
  logic [3:0] nbrWr;
  logic [2:0] clrIdx;
  logic [7:0] eventVec;
  logic       pcEnable, idle, wake;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  event_wake_unit #(.NUM_NBR(4)) u0 (
    .clk(clk), .rstN(rstN), .sensorWr(sensorWr), .nbrWr(nbrWr), .actWr(actWr),
    .haltExec(haltExec), .clrEvent(clrEvent), .clrIdx(clrIdx),
    .eventVec(eventVec), .pcEnable(pcEnable), .idle(idle), .wake(wake)
  );

  task automatic check(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic drive(input logic [5:0] wr, input logic h, input logic c, input int idx);
    sensorWr = wr[0];
    nbrWr    = wr[4:1];
    actWr    = wr[5];
    haltExec = h;
    clrEvent = c;
    clrIdx   = 3'(idx);
  endtask

  task automatic tick();
    @(negedge clk);
    drive(6'd0, 1'b0, 1'b0, 0);
  endtask

  task automatic clearAll();
    for (int k = 0; k < 6; k++) begin
      drive(6'd0, 1'b0, 1'b1, k);
      tick();
    end
  endtask

  initial begin
    rstN = 1'b0;
    drive(6'd0, 1'b0, 1'b0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 vector", eventVec, 0);
    check("R1 idle", idle, 0);
    check("R1 wake", wake, 0);
    check("R1 pcEnable", pcEnable, 1);

    begin
      int expv = 0;
      for (int b = 0; b < 6; b++) begin
        drive(6'(1 << b), 1'b0, 1'b0, 0);
        tick();
        expv |= (1 << b);
        check("R2 set bit", eventVec, expv);
        check("R6 top bits", eventVec[7:6], 0);
      end
      repeat (3) tick();
      check("R3 sticky", eventVec, 8'h3F);
    end

    for (int k = 0; k < 8; k++) begin
      drive(6'h3F, 1'b0, 1'b0, 0);
      tick();
      drive(6'd0, 1'b0, 1'b1, k);
      tick();
      check("R4 clear index", eventVec, (k < 6) ? (8'h3F & ~(1 << k)) : 8'h3F);
    end

    for (int b = 0; b < 6; b++) begin
      clearAll();
      drive(6'(1 << b), 1'b0, 1'b1, b);
      tick();
      check("R5 set wins", eventVec, 1 << b);
    end
    clearAll();
    check("R4 all cleared", eventVec, 0);

    drive(6'd0, 1'b1, 1'b0, 0);
    tick();
    check("R7 idle", idle, 1);
    check("R7 pcEnable", pcEnable, 0);
    check("R7 no wake", wake, 0);
    repeat (3) tick();
    check("R7 idle held", idle, 1);
    drive(6'd0, 1'b1, 1'b0, 0);
    tick();
    check("R10 halt while idle", idle, 1);
    check("R10 no wake", wake, 0);

    for (int b = 0; b < 6; b++) begin
      drive(6'(1 << b), 1'b0, 1'b0, 0);
      tick();
      check("R9 vector at t+1", eventVec, 1 << b);
      check("R9 still idle at t+1", idle, 1);
      check("R9 no wake at t+1", wake, 0);
      tick();
      check("R9 idle drops", idle, 0);
      check("R9 wake high", wake, 1);
      check("R9 pcEnable", pcEnable, 1);
      tick();
      check("R9 wake one cycle", wake, 0);
      check("R10 stays running", idle, 0);
      drive(6'd0, 1'b0, 1'b1, b);
      tick();
      check("R4 clear after wake", eventVec, 0);
      drive(6'd0, 1'b1, 1'b0, 0);
      tick();
      check("R7 re-halt", idle, 1);
    end
    drive(6'd1, 1'b0, 1'b0, 0);
    tick();
    tick();
    tick();
    clearAll();

    drive(6'b000100, 1'b0, 1'b0, 0);
    tick();
    drive(6'd0, 1'b1, 1'b0, 0);
    tick();
    check("R8 halt with pending", idle, 0);
    clearAll();
    drive(6'b100000, 1'b1, 1'b0, 0);
    tick();
    check("R8 halt with write", idle, 0);
    check("R8 vector", eventVec, 8'h20);
    check("R10 no wake while running", wake, 0);
    clearAll();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule